// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by walking a two-level page table in memory. Given a 32-bit virtual address, the kind of access (read or write) and the privilege of the access (user or supervisor), it reads a directory entry, then a table entry, over a single 32-bit request/acknowledge memory port. The start of the walk is the frame number of the page directory, supplied by the caller.

A walk ends in exactly one of two results, each shown for a single cycle. A refill gives the physical frame number and the combined page attributes, ready to load into a translation cache. A fault gives the virtual address and whether the entry was absent or the access broke a rule. It also echoes whether the access was a write and whether it came from user mode. As the walk passes each level, the walker writes back the accessed flag, and for writes the dirty flag of the leaf entry. It does this with a read-modify-write, and only when a flag actually changes. Large pages are not supported: a directory entry that asks for one ends the walk with a fault.

Entry layout used at both levels: bits 31:12 hold the frame number of the next level or of the page. Bit 0 is present, bit 1 writable, bit 2 user, bit 3 write-through, bit 4 cache-disable, bit 5 accessed and bit 8 global. In the leaf entry, bit 6 is dirty. In the directory entry, bit 7 is the large-page flag. The walker never tests bits 11:9.

Top module: `pgw_top`

## Requirements
- R1: The first access of every walk is a read at byte address {dir_base, vaddr[31:22], 2'b00}. dir_base is sampled when the request is accepted.
- R2: The leaf read is at {directory entry bits 31:12, vaddr[21:12], 2'b00}.
- R3: If bit 0 of either entry is 0, the walk ends with a fault and fault_prot = 0. No further memory access of that walk follows the read of the absent entry.
- R4: A present directory entry with bit 7 set ends the walk with a fault, fault_prot = 1. No write-back and no leaf read follow.
- R5: A write is allowed only if bit 1 is set at both levels. A user access is allowed only if bit 2 is set at both levels. A broken rule gives a fault with fault_prot = 1. The directory level is checked before its write-back, and the leaf level before its write-back. fault_vaddr, fault_write and fault_user echo the request.
- R6: A directory entry that passes its checks with bit 5 clear is written back, at the same address, with bit 5 set and all other bits unchanged. If bit 5 is already set, no write is made.
- R7: A leaf entry that passes its checks is written back with bit 5 set, and with bit 6 set when the access is a write. The write is made only if this changes the entry.
- R8: On a refill, refill_ppn is leaf bits 31:12 and refill_vpn is vaddr[31:12]. refill_writable is the AND of bit 1 at both levels, refill_user the AND of bit 2, and refill_global the AND of bit 8. refill_wthru is leaf bit 3, refill_nocache leaf bit 4, and refill_dirty the leaf bit 6 after any update.
- R9: Each accepted request yields exactly one one-cycle pulse, on refill_valid or fault_valid, never both. The next cycle req_ready is high again. req_ready is high only while no walk is in progress.
- R10: Once raised, mem_req stays high, with mem_addr and mem_we unchanged, until mem_ack is seen.
- R11: After reset, req_ready is 1 and mem_req, refill_valid and fault_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_base | input | 20 | Frame number of the page directory |
| req_valid | input | 1 | Start a walk (taken while req_ready is high) |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| refill_valid | output | 1 | One-cycle refill result |
| refill_vpn | output | 20 | Virtual page number of the walk |
| refill_ppn | output | 20 | Physical frame number |
| refill_writable | output | 1 | Combined write permission |
| refill_user | output | 1 | Combined user permission |
| refill_global | output | 1 | Page global at both levels |
| refill_wthru | output | 1 | Write-through attribute of the page |
| refill_nocache | output | 1 | Cache-disable attribute of the page |
| refill_dirty | output | 1 | Dirty flag after the walk |
| fault_valid | output | 1 | One-cycle fault result |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_prot | output | 1 | 1 for a rule violation, 0 for an absent entry |
| fault_write | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was in user mode |

## Verification
The properties assume that memory raises mem_ack for one cycle only, and only while a request is outstanding. They also assume it never acknowledges the same request twice. The bench responder meets this by keeping one pending request at a time and dropping its acknowledge on the cycle after it was given. It adds a random wait of zero to three cycles before each acknowledge. The generated directory and leaf frame numbers point only at pages the bench memory backs, and the directory frame points at a different page. The two entries of a walk therefore never alias, and every write-back lands where the model expects it.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int ADDR_W  = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int LEVELS  = 2;
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int SCALE_W = OFF_W - IDX_W;

    // entry flag positions (shared by both levels unless noted)
    localparam int F_PRESENT = 0;
    localparam int F_WRITE   = 1;
    localparam int F_USER    = 2;
    localparam int F_WTHRU   = 3;
    localparam int F_NOCACHE = 4;
    localparam int F_ACCESS  = 5;
    localparam int F_DIRTY   = 6;   // leaf only
    localparam int F_LARGE   = 7;   // directory only
    localparam int F_GLOBAL  = 8;

    typedef logic [ADDR_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [IDX_W-1:0]   index_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_DIR,
        W_WB_DIR,
        W_RD_LEAF,
        W_WB_LEAF,
        W_REFILL,
        W_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        V_PASS,
        V_ABSENT,
        V_RULE
    } verdict_e;

    typedef struct packed {
        frame_t ppn;
        logic   writable;
        logic   user;
        logic   global_pg;
        logic   wthru;
        logic   nocache;
        logic   dirty;
    } refill_t;

    function automatic word_t entry_address(frame_t frame, index_t idx);
        return {frame, idx, {SCALE_W{1'b0}}};
    endfunction

    function automatic word_t flag_mask(int pos);
        word_t m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pgw_eval.sv
module pgw_eval
    import pgw_pkg::*;
#(
    parameter bit LEAF = 1'b0
) (
    input  word_t    entry,
    input  logic     acc_write,
    input  logic     acc_user,
    input  logic     up_write,
    input  logic     up_user,
    output verdict_e verdict,
    output word_t    entry_upd,
    output logic     need_wb,
    output logic     eff_write,
    output logic     eff_user
);

    logic bad_size;
    logic rule_break;

    always_comb begin
        eff_write  = entry[F_WRITE] & up_write;
        eff_user   = entry[F_USER] & up_user;
        bad_size   = (!LEAF) && entry[F_LARGE];
        rule_break = bad_size || (acc_write && !eff_write) || (acc_user && !eff_user);

        if (!entry[F_PRESENT]) begin
            verdict = V_ABSENT;
        end else if (rule_break) begin
            verdict = V_RULE;
        end else begin
            verdict = V_PASS;
        end
    end

    generate
        if (LEAF) begin : g_leaf
            always_comb begin
                entry_upd = entry | flag_mask(F_ACCESS);
                if (acc_write) begin
                    entry_upd = entry_upd | flag_mask(F_DIRTY);
                end
            end
        end else begin : g_dir
            always_comb begin
                entry_upd = entry | flag_mask(F_ACCESS);
            end
        end
    endgenerate

    assign need_wb = (entry_upd != entry);

endmodule

// File: rtl/pgw_addr.sv
module pgw_addr
    import pgw_pkg::*;
(
    input  logic   use_leaf,
    input  frame_t dir_frame,
    input  frame_t leaf_frame,
    input  frame_t vpn,
    output word_t  addr
);

    index_t dir_idx;
    index_t leaf_idx;

    assign dir_idx  = vpn[FRAME_W-1 -: IDX_W];
    assign leaf_idx = vpn[IDX_W-1:0];

    always_comb begin
        if (use_leaf) begin
            addr = entry_address(leaf_frame, leaf_idx);
        end else begin
            addr = entry_address(dir_frame, dir_idx);
        end
    end

endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [pgw_pkg::FRAME_W-1:0] dir_base,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [pgw_pkg::ADDR_W-1:0] req_vaddr,
    input  logic                      req_write,
    input  logic                      req_user,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [pgw_pkg::ADDR_W-1:0] mem_addr,
    output logic [pgw_pkg::ADDR_W-1:0] mem_wdata,
    input  logic                      mem_ack,
    input  logic [pgw_pkg::ADDR_W-1:0] mem_rdata,
    output logic                      refill_valid,
    output logic [pgw_pkg::FRAME_W-1:0] refill_vpn,
    output logic [pgw_pkg::FRAME_W-1:0] refill_ppn,
    output logic                      refill_writable,
    output logic                      refill_user,
    output logic                      refill_global,
    output logic                      refill_wthru,
    output logic                      refill_nocache,
    output logic                      refill_dirty,
    output logic                      fault_valid,
    output logic [pgw_pkg::ADDR_W-1:0] fault_vaddr,
    output logic                      fault_prot,
    output logic                      fault_write,
    output logic                      fault_user
);

    localparam int DIR_LVL  = 0;
    localparam int LEAF_LVL = LEVELS - 1;

    walk_state_e state;
    word_t       va_q;
    frame_t      dbase_q;
    logic        wr_q;
    logic        usr_q;
    logic        prot_q;
    word_t       dir_q;
    word_t       leaf_q;
    refill_t     rf;

    // per-level evaluation signals
    word_t    ev_in     [LEVELS];
    logic     ev_up_wr  [LEVELS];
    logic     ev_up_us  [LEVELS];
    verdict_e ev_verd   [LEVELS];
    word_t    ev_upd    [LEVELS];
    logic     ev_wb     [LEVELS];
    logic     ev_eff_wr [LEVELS];
    logic     ev_eff_us [LEVELS];

    // entries are judged straight off the read bus in the read states
    assign ev_in[DIR_LVL]     = (state == W_RD_DIR)  ? mem_rdata : dir_q;
    assign ev_in[LEAF_LVL]    = (state == W_RD_LEAF) ? mem_rdata : leaf_q;
    assign ev_up_wr[DIR_LVL]  = 1'b1;
    assign ev_up_us[DIR_LVL]  = 1'b1;
    assign ev_up_wr[LEAF_LVL] = ev_eff_wr[DIR_LVL];
    assign ev_up_us[LEAF_LVL] = ev_eff_us[DIR_LVL];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
            pgw_eval #(
                .LEAF (g == LEVELS - 1)
            ) u_eval (
                .entry     (ev_in[g]),
                .acc_write (wr_q),
                .acc_user  (usr_q),
                .up_write  (ev_up_wr[g]),
                .up_user   (ev_up_us[g]),
                .verdict   (ev_verd[g]),
                .entry_upd (ev_upd[g]),
                .need_wb   (ev_wb[g]),
                .eff_write (ev_eff_wr[g]),
                .eff_user  (ev_eff_us[g])
            );
        end
    endgenerate

    logic use_leaf;
    assign use_leaf = (state == W_RD_LEAF) || (state == W_WB_LEAF);

    pgw_addr u_addr (
        .use_leaf   (use_leaf),
        .dir_frame  (dbase_q),
        .leaf_frame (dir_q[ADDR_W-1:OFF_W]),
        .vpn        (va_q[ADDR_W-1:OFF_W]),
        .addr       (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= W_IDLE;
            va_q    <= '0;
            dbase_q <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            prot_q  <= 1'b0;
            dir_q   <= '0;
            leaf_q  <= '0;
        end else begin
            case (state)
                W_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        dbase_q <= dir_base;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        state   <= W_RD_DIR;
                    end
                end
                W_RD_DIR: begin
                    if (mem_ack) begin
                        case (ev_verd[DIR_LVL])
                            V_ABSENT: begin
                                prot_q <= 1'b0;
                                state  <= W_FAULT;
                            end
                            V_RULE: begin
                                prot_q <= 1'b1;
                                state  <= W_FAULT;
                            end
                            default: begin
                                dir_q <= ev_upd[DIR_LVL];
                                state <= ev_wb[DIR_LVL] ? W_WB_DIR : W_RD_LEAF;
                            end
                        endcase
                    end
                end
                W_WB_DIR: begin
                    if (mem_ack) begin
                        state <= W_RD_LEAF;
                    end
                end
                W_RD_LEAF: begin
                    if (mem_ack) begin
                        case (ev_verd[LEAF_LVL])
                            V_ABSENT: begin
                                prot_q <= 1'b0;
                                state  <= W_FAULT;
                            end
                            V_RULE: begin
                                prot_q <= 1'b1;
                                state  <= W_FAULT;
                            end
                            default: begin
                                leaf_q <= ev_upd[LEAF_LVL];
                                state  <= ev_wb[LEAF_LVL] ? W_WB_LEAF : W_REFILL;
                            end
                        endcase
                    end
                end
                W_WB_LEAF: begin
                    if (mem_ack) begin
                        state <= W_REFILL;
                    end
                end
                W_REFILL: state <= W_IDLE;
                W_FAULT:  state <= W_IDLE;
                default:  state <= W_IDLE;
            endcase
        end
    end

    // memory port
    assign mem_req   = (state == W_RD_DIR) || (state == W_WB_DIR) ||
                       (state == W_RD_LEAF) || (state == W_WB_LEAF);
    assign mem_we    = (state == W_WB_DIR) || (state == W_WB_LEAF);
    assign mem_wdata = (state == W_WB_DIR) ? dir_q : leaf_q;
    assign req_ready = (state == W_IDLE);

    // refill result
    always_comb begin
        rf.ppn       = leaf_q[ADDR_W-1:OFF_W];
        rf.writable  = ev_eff_wr[LEAF_LVL];
        rf.user      = ev_eff_us[LEAF_LVL];
        rf.global_pg = dir_q[F_GLOBAL] & leaf_q[F_GLOBAL];
        rf.wthru     = leaf_q[F_WTHRU];
        rf.nocache   = leaf_q[F_NOCACHE];
        rf.dirty     = leaf_q[F_DIRTY];
    end

    assign refill_valid    = (state == W_REFILL);
    assign refill_vpn      = va_q[ADDR_W-1:OFF_W];
    assign refill_ppn      = rf.ppn;
    assign refill_writable = rf.writable;
    assign refill_user     = rf.user;
    assign refill_global   = rf.global_pg;
    assign refill_wthru    = rf.wthru;
    assign refill_nocache  = rf.nocache;
    assign refill_dirty    = rf.dirty;

    // fault result
    assign fault_valid = (state == W_FAULT);
    assign fault_vaddr = va_q;
    assign fault_prot  = prot_q;
    assign fault_write = wr_q;
    assign fault_user  = usr_q;

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk
    import pgw_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         req_ready,
    input logic         mem_req,
    input logic         mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic         mem_ack,
    input logic         refill_valid,
    input logic         fault_valid
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    single_result_chk: assert property (@(posedge clk) disable iff (rst)
        !(refill_valid && fault_valid));

    // R9
    result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (refill_valid || fault_valid) |=> (req_ready && !refill_valid && !fault_valid));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req && !refill_valid && !fault_valid));

    // R6
    wb_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[F_PRESENT] && mem_wdata[F_ACCESS]));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        $fell(rst) |-> (req_ready && !mem_req));

endmodule

bind pgw_top pgw_chk u_chk (.*);

// File: tb/sim_pgw_top.sv
`timescale 1ns/1ps
module sim_pgw_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        refill_valid;
    logic [19:0] refill_vpn, refill_ppn;
    logic        refill_writable, refill_user, refill_global;
    logic        refill_wthru, refill_nocache, refill_dirty;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic        fault_prot, fault_write, fault_user;

    always #2 clk = ~clk;

    pgw_top u0 (
        .clk(clk), .rst(rst), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .refill_writable(refill_writable), .refill_user(refill_user),
        .refill_global(refill_global), .refill_wthru(refill_wthru),
        .refill_nocache(refill_nocache), .refill_dirty(refill_dirty),
        .fault_valid(fault_valid), .fault_vaddr(fault_vaddr), .fault_prot(fault_prot),
        .fault_write(fault_write), .fault_user(fault_user)
    );

    // backing store: four 4 KB pages, indexed by address bits 13:2
    logic [31:0] mem [0:4095];
    logic [31:0] log_addr [0:7];
    logic        log_we   [0:7];
    logic [31:0] log_data [0:7];
    int          acc_n = 0;
    int          lat = 0;
    int          wcnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                wcnt      <= 0;
                lat       <= $urandom_range(0, 3);
                mem_rdata <= mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
                if (acc_n < 8) begin
                    log_addr[acc_n] <= mem_addr;
                    log_we[acc_n]   <= mem_we;
                    log_data[acc_n] <= mem_wdata;
                end
                acc_n <= acc_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    int vectors = 0;
    int fails = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // expected outcome, built from the requirements
    int          e_n;
    logic [31:0] e_addr [0:3];
    logic        e_we   [0:3];
    logic [31:0] e_data [0:3];
    string       e_tag  [0:3];
    logic        e_fault, e_prot;
    logic [31:0] e_pde, e_pte;
    logic [19:0] e_ppn;
    logic        e_w, e_u, e_g, e_wt, e_cd, e_d;

    task automatic push(input logic [31:0] a, input logic we, input logic [31:0] d, input string tag);
        e_addr[e_n] = a; e_we[e_n] = we; e_data[e_n] = d; e_tag[e_n] = tag;
        e_n++;
    endtask

    task automatic model(input logic [19:0] db, input logic [31:0] va,
                         input logic [31:0] pde, input logic [31:0] pte,
                         input logic wr, input logic us);
        logic [31:0] pa_d, pa_t, npte;
        e_n = 0; e_fault = 1'b0; e_prot = 1'b0;
        e_pde = pde; e_pte = pte;
        pa_d = {db, va[31:22], 2'b00};
        push(pa_d, 1'b0, 32'h0, "R1");
        if (!pde[0]) begin e_fault = 1'b1; return; end
        if (pde[7] || (wr && !pde[1]) || (us && !pde[2])) begin
            e_fault = 1'b1; e_prot = 1'b1; return;
        end
        if (!pde[5]) begin
            e_pde = pde | 32'h20;
            push(pa_d, 1'b1, e_pde, "R6");
        end
        pa_t = {pde[31:12], va[21:12], 2'b00};
        push(pa_t, 1'b0, 32'h0, "R2");
        if (!pte[0]) begin e_fault = 1'b1; return; end
        if ((wr && !(pde[1] & pte[1])) || (us && !(pde[2] & pte[2]))) begin
            e_fault = 1'b1; e_prot = 1'b1; return;
        end
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (npte != pte) push(pa_t, 1'b1, npte, "R7");
        e_pte = npte;
        e_ppn = pte[31:12];
        e_w   = pde[1] & pte[1];
        e_u   = pde[2] & pte[2];
        e_g   = pde[8] & pte[8];
        e_wt  = pte[3];
        e_cd  = pte[4];
        e_d   = npte[6];
    endtask

    task automatic walk(input logic [19:0] db, input logic [31:0] va,
                        input logic [31:0] pde, input logic [31:0] pte,
                        input logic wr, input logic us);
        logic [11:0] di, ti;
        int t;
        bit got;
        di = {db[1:0], va[31:22]};
        ti = {pde[13:12], va[21:12]};
        mem[di] = pde;
        mem[ti] = pte;
        model(db, va, pde, pte, wr, us);
        acc_n = 0;
        while (!req_ready) @(negedge clk);
        dir_base = db; req_vaddr = va; req_write = wr; req_user = us;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        dir_base = ~db;
        got = 1'b0;
        for (t = 0; t < 100; t++) begin
            if (refill_valid || fault_valid) begin got = 1'b1; break; end
            @(negedge clk);
        end
        check(got, "R9 result seen", {31'b0, got}, 32'h1);
        if (!got) return;
        check(!(refill_valid && fault_valid), "R9 single result",
              {30'b0, refill_valid, fault_valid}, 32'h0);
        check(fault_valid == e_fault, e_fault ? (e_prot ? "R5 fault kind" : "R3 fault kind") : "R8 refill kind",
              {31'b0, fault_valid}, {31'b0, e_fault});
        if (fault_valid && e_fault) begin
            check(fault_prot == e_prot, e_prot ? "R5 prot flag" : "R3 prot flag",
                  {31'b0, fault_prot}, {31'b0, e_prot});
            check(fault_vaddr == va, "R5 fault vaddr", fault_vaddr, va);
            check({fault_write, fault_user} == {wr, us}, "R5 fault access",
                  {30'b0, fault_write, fault_user}, {30'b0, wr, us});
        end
        if (refill_valid && !e_fault) begin
            check(refill_ppn == e_ppn, "R8 ppn", {12'b0, refill_ppn}, {12'b0, e_ppn});
            check(refill_vpn == va[31:12], "R8 vpn", {12'b0, refill_vpn}, {12'b0, va[31:12]});
            check({refill_writable, refill_user, refill_global, refill_wthru, refill_nocache, refill_dirty}
                  == {e_w, e_u, e_g, e_wt, e_cd, e_d}, "R8 attributes",
                  {26'b0, refill_writable, refill_user, refill_global, refill_wthru, refill_nocache, refill_dirty},
                  {26'b0, e_w, e_u, e_g, e_wt, e_cd, e_d});
        end
        check(acc_n == e_n, "R3 R7 access count", acc_n, e_n);
        for (int i = 0; i < e_n && i < acc_n; i++) begin
            check(log_addr[i] == e_addr[i], e_tag[i], log_addr[i], e_addr[i]);
            check(log_we[i] == e_we[i], e_tag[i], {31'b0, log_we[i]}, {31'b0, e_we[i]});
            if (e_we[i]) check(log_data[i] == e_data[i], e_tag[i], log_data[i], e_data[i]);
        end
        check(mem[di] == e_pde, "R6 directory word", mem[di], e_pde);
        check(mem[ti] == e_pte, "R7 leaf word", mem[ti], e_pte);
        @(negedge clk);
        check(req_ready && !refill_valid && !fault_valid, "R9 back to idle",
              {29'b0, req_ready, refill_valid, fault_valid}, 32'h4);
    endtask

    function automatic logic [31:0] rnd_entry(input bit dir_level);
        logic [31:0] r, e;
        r = $urandom;
        e = $urandom;
        e[0] = (r[2:0] != 3'd0);
        if (dir_level) begin
            e[7] = (r[5:3] == 3'd0);
            e[13] = 1'b1;
        end
        return e;
    endfunction

    initial begin
        logic [19:0] db;
        logic [31:0] va, pde, pte, r;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check(req_ready && !mem_req && !refill_valid && !fault_valid, "R11 reset state",
              {28'b0, req_ready, mem_req, refill_valid, fault_valid}, 32'h8);

        // directed corner cases
        db = 20'hABC40; va = 32'h1234_5678;
        walk(db, va, 32'h0000_3007, 32'h5555_5007, 1'b0, 1'b1);  // R6 R7 both A clear, user read
        walk(db, va, 32'h0000_3007, 32'h5555_5007, 1'b1, 1'b1);  // R7 write sets D
        walk(db, va, 32'h0000_3027, 32'h5555_5067, 1'b1, 1'b0);  // R6 R7 nothing to write
        walk(db, va, 32'hFFFF_FFFE, 32'h5555_5007, 1'b0, 1'b0);  // R3 absent directory
        walk(db, va, 32'h0000_2027, 32'hFFFF_FFFE, 1'b1, 1'b1);  // R3 absent leaf
        walk(db, va, 32'h0000_30A7, 32'h5555_5007, 1'b0, 1'b0);  // R4 large page
        walk(db, va, 32'h0000_3005, 32'h5555_5007, 1'b1, 1'b0);  // R5 directory read-only
        walk(db, va, 32'h0000_3007, 32'h5555_5003, 1'b0, 1'b1);  // R5 leaf supervisor
        walk(db, va, 32'h0000_3007, 32'h5555_5005, 1'b1, 1'b0);  // R5 leaf read-only
        walk(db, va, 32'h0000_3103, 32'h5555_511F, 1'b0, 1'b0);  // R8 global both
        walk(db, va, 32'h0000_3103, 32'h5555_5007, 1'b0, 1'b0);  // R8 global only dir
        walk(20'h00001, 32'hFFFF_F000, 32'hFFFF_2027, 32'h0000_1027, 1'b0, 1'b0); // R1 R2 edges

        // constrained random walks
        for (int n = 0; n < 400; n++) begin
            r   = $urandom;
            db  = {r[31:14], 1'b0, r[0]};
            va  = $urandom;
            pde = rnd_entry(1'b1);
            pte = rnd_entry(1'b0);
            r   = $urandom;
            walk(db, va, pde, pte, r[0], r[1]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule